// File: doc/BRIEF.md
# Interrupt Request Output Controller

This block gathers event pulses from a set of status sources and merges them into one active-low interrupt request. Each source has a status bit that is set on the rising edge of its input. Software clears the bit with a write-one-to-clear strobe. A mask bit decides whether that source may raise the request.

A two-bit duration field sets how long the request stays asserted:
- a timed pulse of 3, 15 or 63 reference-clock periods, or
- a sticky level that holds until software masks or clears the cause.

The pin is brought out as an output-enable and data pair. Three electrical behaviours are selected by a drive field: open drain, push-pull active low and push-pull active high. At reset every source is masked and the pin is open drain, so the pin is not driven. Software must program the mask and drive fields before the line can signal anything. The register bus in front of the block is not part of it; configuration arrives as write strobes with data.

Top module: `irq_out_ctrl`

## Requirements
- R1: After reset the status bits are 0, every mask bit is 0 (source disabled), the duration code is 00 and the drive code is 00 (open drain), so `irq_oe_o` is 0.
- R2: A status bit is set by a 0-to-1 change of its source input and remains set until cleared. A source held high does not set its bit again after a clear.
- R3: A 1 on a `clr_i` bit for one cycle clears that status bit. If a rising edge of the same source is seen in that cycle, the bit stays set.
- R4: A source whose mask bit is 0 still sets its status bit but never asserts the request, in any duration mode.
- R5: With duration codes 00, 01 and 10, an unmasked rising edge asserts the request for exactly 3, 15 or 63 clock cycles respectively.
- R6: An unmasked rising edge during a timed pulse restarts the count, so the request lasts that full length from the new event.
- R7: A clear of status bits has no effect on a timed pulse already in progress.
- R8: With duration code 11, the request is asserted while any status bit with mask 1 is set. It stays asserted after the source input falls, and it releases once the bit is cleared or masked.
- R9: The drive codes behave as follows:
  - 00 (open drain): `irq_oe_o` equals the request and `irq_do_o` is 0.
  - 01 (push-pull, active low): `irq_oe_o` is 1 and `irq_do_o` is the inverted request.
  - 10 (push-pull, active high): `irq_oe_o` is 1 and `irq_do_o` equals the request.
  - 11: same as 00.
- R10: The request becomes visible at the pin outputs in the cycle after the clock edge that samples the unmasked rising edge of a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Source condition levels |
| clr_i | input | NUM_SRC | Write-one-to-clear strobes for the status bits |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_i | input | NUM_SRC | Mask write data, 1 = source enabled |
| cfg_we_i | input | 1 | Configuration write strobe |
| dur_sel_i | input | 2 | Duration code write data |
| drv_sel_i | input | 2 | Drive code write data |
| status_o | output | NUM_SRC | Latched status bits |
| irq_oe_o | output | 1 | Pin output enable |
| irq_do_o | output | 1 | Pin output data |

## Verification
A wrong status, mask or counter value shows on the pins within a cycle or two. A stuck or early-cleared status bit shows up at once on `status_o`. In sticky mode the same fault gives a request that does not match the masked status. A counter fault shows as a pulse of the wrong width, so pulse widths are measured in cycles at the pin, and the widths for retrigger and for a clear during a pulse are checked explicitly. A cycle-accurate model is compared on every clock, so a fault in the drive mapping or in the mode transitions is caught on the first cycle it differs.

// File: rtl/irq_out_pkg.sv
package irq_out_pkg;
  typedef enum logic [1:0] {
    DUR_SHORT = 2'b00,
    DUR_MID   = 2'b01,
    DUR_LONG  = 2'b10,
    DUR_HOLD  = 2'b11
  } dur_sel_e;

  typedef enum logic [1:0] {
    DRV_OPEN    = 2'b00,
    DRV_PUSH_LO = 2'b01,
    DRV_PUSH_HI = 2'b10,
    DRV_ALT     = 2'b11
  } drv_sel_e;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic clr_i,
  output logic rise_o,
  output logic status_o
);
  logic src_q;
  logic status_q;

  assign rise_o   = src_i & ~src_q;
  assign status_o = status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= 1'b0;
      status_q <= 1'b0;
    end else begin
      src_q    <= src_i;
      // set wins over a simultaneous clear
      status_q <= rise_o | (status_q & ~clr_i);
    end
  end
endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer
  import irq_out_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     trig_i,
  input  dur_sel_e dur_i,
  output logic     busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  // pulse length minus one: 2, 14, 62 for codes 0, 1, 2
  function automatic logic [CNT_W-1:0] load_val(dur_sel_e d);
    int v;
    v = (1 << (2 * int'(d) + 2)) - 2;
    return CNT_W'(v);
  endfunction

  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (dur_i == DUR_HOLD) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (trig_i) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val(dur_i);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
  import irq_out_pkg::*;
(
  input  logic     req_i,
  input  drv_sel_e drv_i,
  output logic     oe_o,
  output logic     do_o
);
  always_comb begin
    unique case (drv_i)
      DRV_PUSH_LO: begin oe_o = 1'b1;  do_o = ~req_i; end
      DRV_PUSH_HI: begin oe_o = 1'b1;  do_o = req_i;  end
      default:     begin oe_o = req_i; do_o = 1'b0;   end
    endcase
  end
endmodule

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl
  import irq_out_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         dur_sel_i,
  input  logic [1:0]         drv_sel_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic               irq_oe_o,
  output logic               irq_do_o
);
  logic [NUM_SRC-1:0] src_rise;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] mask_q;
  dur_sel_e           dur_q;
  drv_sel_e           drv_q;
  logic               trig;
  logic               busy;
  logic               hold_req;
  logic               req;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_src_latch u_latch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_i[i]),
      .clr_i   (clr_i[i]),
      .rise_o  (src_rise[i]),
      .status_o(status[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      dur_q  <= DUR_SHORT;
      drv_q  <= DRV_OPEN;
    end else begin
      if (mask_we_i) mask_q <= mask_i;
      if (cfg_we_i) begin
        dur_q <= dur_sel_e'(dur_sel_i);
        drv_q <= drv_sel_e'(drv_sel_i);
      end
    end
  end

  assign trig     = |(src_rise & mask_q);
  assign hold_req = |(status & mask_q);

  irq_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig),
    .dur_i (dur_q),
    .busy_o(busy)
  );

  assign req = (dur_q == DUR_HOLD) ? hold_req : busy;

  irq_pin_drive u_drive (
    .req_i(req),
    .drv_i(drv_q),
    .oe_o (irq_oe_o),
    .do_o (irq_do_o)
  );

  assign status_o = status;
endmodule

// File: rtl/irq_out_ctrl_chk.sv
module irq_out_ctrl_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] clr_i,
  input logic               mask_we_i,
  input logic               cfg_we_i,
  input logic [NUM_SRC-1:0] src_rise,
  input logic [NUM_SRC-1:0] status_o,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [1:0]         dur_q,
  input logic [1:0]         drv_q,
  input logic               req,
  input logic               irq_oe_o,
  input logic               irq_do_o
);
  assert_set_on_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_rise) |=> ((status_o & $past(src_rise)) == $past(src_rise)));

  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~src_rise)) |=> ((status_o & $past(clr_i & ~src_rise)) == '0));

  assert_masked_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dur_q == 2'b11 && mask_q == '0) |-> !req);

  assert_hold_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dur_q == 2'b11 && req && !mask_we_i && !cfg_we_i && clr_i == '0) |=> req);

  assert_open_drain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_q == 2'b00 || drv_q == 2'b11) |-> (!irq_do_o && (irq_oe_o == req)));

  assert_push_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_q == 2'b01) |-> (irq_oe_o && (irq_do_o == !req)));

  assert_trigger_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dur_q != 2'b11 && |(src_rise & mask_q) && !cfg_we_i) |=> req);
endmodule

bind irq_out_ctrl irq_out_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .mask_we_i(mask_we_i),
  .cfg_we_i (cfg_we_i),
  .src_rise (src_rise),
  .status_o (status_o),
  .mask_q   (mask_q),
  .dur_q    (dur_q),
  .drv_q    (drv_q),
  .req      (req),
  .irq_oe_o (irq_oe_o),
  .irq_do_o (irq_do_o)
);

// File: tb/irq_out_ctrl_tb.sv
module irq_out_ctrl_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src = '0, clr = '0, mask_d = '0;
  logic         mask_we = 1'b0, cfg_we = 1'b0;
  logic [1:0]   dur_d = 2'b00, drv_d = 2'b00;
  logic [N-1:0] status;
  logic         oe, dout;

  int checks = 0, fails = 0;
  string phase = "R1";

  // reference model state
  logic [N-1:0] m_prev, m_status, m_mask;
  logic [1:0]   m_dur, m_drv;
  int           m_rem;
  int           run = 0, last_w = 0;

  always #5 clk = ~clk;

  irq_out_ctrl #(.NUM_SRC(N), .CNT_W(6)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .clr_i(clr),
    .mask_we_i(mask_we), .mask_i(mask_d), .cfg_we_i(cfg_we),
    .dur_sel_i(dur_d), .drv_sel_i(drv_d),
    .status_o(status), .irq_oe_o(oe), .irq_do_o(dout)
  );

  function automatic int len_of(logic [1:0] d);
    case (d)
      2'b00:   return 3;
      2'b01:   return 15;
      default: return 63;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = '0; m_status = '0; m_mask = '0;
      m_dur = 2'b00; m_drv = 2'b00; m_rem = 0;
    end else begin
      logic [N-1:0] rise;
      rise = src & ~m_prev;
      if (m_dur == 2'b11) m_rem = 0;
      else if (|(rise & m_mask)) m_rem = len_of(m_dur);
      else if (m_rem > 0) m_rem = m_rem - 1;
      m_status = (m_status & ~clr) | rise;
      m_prev = src;
      if (mask_we) m_mask = mask_d;
      if (cfg_we) begin m_dur = dur_d; m_drv = drv_d; end
    end
  end

  function automatic logic m_req();
    return (m_dur == 2'b11) ? |(m_status & m_mask) : (m_rem > 0);
  endfunction

  function automatic logic pin_active();
    return oe && ((m_drv == 2'b10) ? dout : !dout);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic eoe, edo;
      case (m_drv)
        2'b01:   begin eoe = 1'b1;    edo = !m_req(); end
        2'b10:   begin eoe = 1'b1;    edo = m_req();  end
        default: begin eoe = m_req(); edo = 1'b0;     end
      endcase
      chk({status, oe, dout} == {m_status, eoe, edo}, {phase, " per-cycle"},
          int'({status, oe, dout}), int'({m_status, eoe, edo}));
      if (pin_active()) run++;
      else if (run > 0) begin last_w = run; run = 0; end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_src(logic [N-1:0] v);
    @(negedge clk); src = v;
  endtask
  task automatic do_clr(logic [N-1:0] v);
    @(negedge clk); clr = v;
    @(negedge clk); clr = '0;
  endtask
  task automatic wr_mask(logic [N-1:0] v);
    @(negedge clk); mask_we = 1'b1; mask_d = v;
    @(negedge clk); mask_we = 1'b0;
  endtask
  task automatic wr_cfg(logic [1:0] d, logic [1:0] m);
    @(negedge clk); cfg_we = 1'b1; dur_d = d; drv_d = m;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    phase = "R1";
    chk(oe == 1'b0, "R1 oe after reset", oe, 0);
    chk(status == '0, "R1 status after reset", status, 0);
    set_src(8'h01); set_src(8'h00); tick(2);
    chk(status == 8'h01, "R2 status set while masked", status, 1);
    chk(oe == 1'b0 && last_w == 0, "R1 masked open drain undriven", oe, 0);

    phase = "R4";
    wr_cfg(2'b00, 2'b01); do_clr(8'hff); wr_mask(8'h01);
    set_src(8'h02); tick(3);
    chk(status == 8'h02, "R4 masked source sets status", status, 2);
    chk(last_w == 0 && run == 0, "R4 masked source no request", run, 0);

    phase = "R5";
    set_src(8'h03); tick(6);
    chk(last_w == 3, "R5 code 00 width", last_w, 3);
    set_src(8'h00); wr_cfg(2'b01, 2'b01);
    set_src(8'h01); @(negedge clk);
    chk(pin_active(), "R10 request one cycle after edge", pin_active(), 1);
    tick(20);
    chk(last_w == 15, "R5 code 01 width", last_w, 15);
    set_src(8'h00); wr_cfg(2'b10, 2'b01);
    set_src(8'h01); tick(70);
    chk(last_w == 63, "R5 code 10 width", last_w, 63);

    phase = "R6";
    set_src(8'h00); wr_cfg(2'b01, 2'b01); wr_mask(8'h05);
    set_src(8'h01); tick(4); set_src(8'h05); tick(25);
    chk(last_w == 20, "R6 retrigger restarts count", last_w, 20);

    phase = "R7";
    set_src(8'h00); set_src(8'h01); tick(3); do_clr(8'hff); tick(20);
    chk(last_w == 15, "R7 clear keeps pulse", last_w, 15);
    chk(status == 8'h00, "R3 clear resets status", status, 0);

    phase = "R3";
    set_src(8'h00);
    @(negedge clk); src = 8'h01; clr = 8'h01;
    @(negedge clk); clr = '0;
    tick(1);
    chk(status[0] == 1'b1, "R3 set wins over clear", status[0], 1);
    tick(20);
    phase = "R2";
    do_clr(8'h01); tick(2);
    chk(status[0] == 1'b0, "R2 held level no re-set", status[0], 0);

    phase = "R8";
    set_src(8'h00); do_clr(8'hff); wr_cfg(2'b11, 2'b01); wr_mask(8'h01);
    set_src(8'h01); set_src(8'h00); tick(20);
    chk(pin_active(), "R8 held after source falls", pin_active(), 1);
    do_clr(8'h01); tick(1);
    chk(!pin_active(), "R8 clear releases", pin_active(), 0);
    set_src(8'h01); tick(2);
    chk(pin_active(), "R8 reassert", pin_active(), 1);
    wr_mask(8'h00); tick(1);
    chk(!pin_active() && status[0], "R8 mask releases", pin_active(), 0);
    set_src(8'h00);

    phase = "R9";
    wr_mask(8'h01); tick(1);
    chk(oe && !dout, "R9 push-pull low asserted", {oe, dout}, 2);
    wr_cfg(2'b11, 2'b10); tick(1);
    chk(oe && dout, "R9 push-pull high asserted", {oe, dout}, 3);
    wr_cfg(2'b11, 2'b00); tick(1);
    chk(oe && !dout, "R9 open drain asserted", {oe, dout}, 2);
    do_clr(8'h01); tick(1);
    chk(!oe && !dout, "R9 open drain released", {oe, dout}, 0);
    wr_cfg(2'b11, 2'b11); tick(1);
    chk(!oe, "R9 code 11 idle undriven", oe, 0);
    set_src(8'h01); tick(2);
    chk(oe && !dout, "R9 code 11 acts as open drain", {oe, dout}, 2);
    do_clr(8'h01); wr_cfg(2'b11, 2'b10); tick(1);
    chk(oe && !dout, "R9 push-pull high idle", {oe, dout}, 2);
    tick(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule